// File: doc/BRIEF.md
# Byte-Lane Write and Select Control for a Synchronous SRAM

This block is the control part of a pipelined synchronous SRAM whose word is four 9-bit lanes. Each lane is eight data bits plus one parity bit. On every running clock edge it samples three select inputs and the write controls. It then presents registered per-lane write strobes, the matching bit-level write masks for data and parity, and a registered device-selected flag.

The block registers the write data on its way in and the array read data on its way out. The output-drive enable comes from the asynchronous output-enable input, which is qualified by the registered select flag and suppressed while any lane write is active.

A sleep input stops all state from advancing, so every register keeps its value. The block exports a clock-run enable so that a clock-gating cell can use it. The storage array itself sits outside this block.

Top module: `sram_byte_ctrl`

## Requirements
- R1: When `allWriteN` is low at a running edge and the device is selected, all four `laneStrobe` bits are 1 after that edge, whatever `laneWrN` and `laneGateN` hold.
- R2: When `allWriteN` is high and `laneGateN` is low at a running edge with the device selected, `laneStrobe[i]` after that edge equals the inverse of `laneWrN[i]`.
- R3: When both `allWriteN` and `laneGateN` are high at a running edge, no `laneStrobe` bit is set after it.
- R4: Lane i covers data bits 8i to 8i+7 and parity bit i. `dataWe[8i+7:8i]` is all ones and `parWe[i]` is 1 exactly when `laneStrobe[i]` is 1, and both are otherwise zero.
- R5: `devSel` is set after a running edge exactly when `chipEnN` was low, `selHi` was high and `selLoN` was low at that edge.
- R6: An edge at which the device is not selected leaves every `laneStrobe`, `dataWe` and `parWe` bit at 0.
- R7: `driveEn` is 1 only while `outEnN` is low, `devSel` is 1 and no `laneStrobe` bit is set. It follows `outEnN` with no clock edge.
- R8: `wrDataQ`/`wrParQ` and `rdDataQ`/`rdParQ` hold the values that `wrData`/`wrPar` and `rdData`/`rdPar` had at the last running edge.
- R9: While `sleepReq` is high, `clkRun` is 0 and every registered output keeps its value across edges. While `sleepReq` is low, `clkRun` is 1.
- R10: While `rstN` is low, `devSel`, the strobes, the masks and all data registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepReq | input | 1 | Sleep request, high stops all state |
| chipEnN | input | 1 | Chip enable, active low |
| selHi | input | 1 | Select, active high |
| selLoN | input | 1 | Select, active low |
| allWriteN | input | 1 | Whole-word write, active low |
| laneGateN | input | 1 | Pass-through gate for lane enables, active low |
| laneWrN | input | 4 | Per-lane write enables, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| wrData | input | 32 | Write data, lane i in bits 8i..8i+7 |
| wrPar | input | 4 | Write parity, bit i for lane i |
| rdData | input | 32 | Read data from the array |
| rdPar | input | 4 | Read parity from the array |
| laneStrobe | output | 4 | Registered lane write strobes |
| devSel | output | 1 | Registered device-selected flag |
| dataWe | output | 32 | Bit write mask for data |
| parWe | output | 4 | Bit write mask for parity |
| wrDataQ | output | 32 | Registered write data |
| wrParQ | output | 4 | Registered write parity |
| rdDataQ | output | 32 | Registered read data |
| rdParQ | output | 4 | Registered read parity |
| driveEn | output | 1 | Output driver enable |
| clkRun | output | 1 | Clock-run enable for a gating cell |

## Verification
The write decode is tried with a whole-word write while every lane enable is inactive, which shows that the global write overrides the lanes. Byte writes with alternating and single-lane masks show that the lane-to-bit mapping is correct. A blocked gate with every lane enable active shows that the gate really blocks. Each of the three selects is dropped on its own during a write, which shows that a single inactive select kills the strobes. The output enable is toggled between clock edges to prove that the drive enable has no clock in its path. A sleep stretch with changing inputs shows that all state is held.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  parameter int LANES     = 4;
  parameter int LANE_BITS = 8;
  localparam int DATA_W   = LANES * LANE_BITS;

  typedef struct packed {
    logic             devSel;
    logic [LANES-1:0] laneWr;
  } ctrlStrobe_t;
endpackage

// File: rtl/sram_sel_decode.sv
module sram_sel_decode (
  input  logic chipEnN,
  input  logic selHi,
  input  logic selLoN,
  input  logic sleepReq,
  output logic devHit,
  output logic clkRun
);
  // All three selects must agree; sleep stops the clock.
  assign devHit = ~chipEnN & selHi & ~selLoN;
  assign clkRun = ~sleepReq;
endmodule

// File: rtl/sram_lane_ctrl_core.sv
module sram_lane_ctrl_core
  import sram_lane_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkRun,
  input  logic             devHit,
  input  logic             allWriteN,
  input  logic             laneGateN,
  input  logic [LANES-1:0] laneWrN,
  output ctrlStrobe_t      ctrl
);
  logic [LANES-1:0] laneNext;
  logic             wholeWord;
  logic             passLanes;

  assign wholeWord = ~allWriteN;
  assign passLanes = ~laneGateN;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneNext[g] = devHit & (wholeWord | (passLanes & ~laneWrN[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl <= '0;
    end else if (clkRun) begin
      ctrl.devSel <= devHit;
      ctrl.laneWr <= laneNext;
    end
  end

  // R1
  global_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clkRun) && $past(devHit) && !$past(allWriteN)) |-> (&ctrl.laneWr));

  // R3
  gate_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clkRun) && $past(allWriteN) && $past(laneGateN)) |-> (ctrl.laneWr == '0));

  // R5
  sel_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clkRun)) |-> (ctrl.devSel == $past(devHit)));

  // R6
  no_strobe_unsel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.laneWr != '0) |-> ctrl.devSel);

  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(clkRun)) |-> $stable(ctrl));
endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath
  import sram_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkRun,
  input  ctrlStrobe_t       ctrl,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  wrPar,
  input  logic [DATA_W-1:0] rdData,
  input  logic [LANES-1:0]  rdPar,
  output logic [DATA_W-1:0] dataWe,
  output logic [LANES-1:0]  parWe,
  output logic [DATA_W-1:0] wrDataQ,
  output logic [LANES-1:0]  wrParQ,
  output logic [DATA_W-1:0] rdDataQ,
  output logic [LANES-1:0]  rdParQ,
  output logic              driveEn
);
  logic anyWrite;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign dataWe[g*LANE_BITS +: LANE_BITS] = {LANE_BITS{ctrl.laneWr[g]}};
    assign parWe[g] = ctrl.laneWr[g];

    // R4
    lane_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
      parWe[g] ? (dataWe[g*LANE_BITS +: LANE_BITS] == '1)
               : (dataWe[g*LANE_BITS +: LANE_BITS] == '0));
  end

  assign anyWrite = |ctrl.laneWr;
  assign driveEn  = ~outEnN & ctrl.devSel & ~anyWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrDataQ <= '0;
      wrParQ  <= '0;
      rdDataQ <= '0;
      rdParQ  <= '0;
    end else if (clkRun) begin
      wrDataQ <= wrData;
      wrParQ  <= wrPar;
      rdDataQ <= rdData;
      rdParQ  <= rdPar;
    end
  end

  // R7
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe != '0) |-> !driveEn);

  // R8
  wr_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clkRun)) |-> (wrDataQ == $past(wrData) && wrParQ == $past(wrPar)));

  // R8
  rd_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(clkRun)) |-> (rdDataQ == $past(rdData) && rdParQ == $past(rdPar)));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(clkRun)) |-> ($stable(wrDataQ) && $stable(rdDataQ)));
endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepReq,
  input  logic              chipEnN,
  input  logic              selHi,
  input  logic              selLoN,
  input  logic              allWriteN,
  input  logic              laneGateN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  wrPar,
  input  logic [DATA_W-1:0] rdData,
  input  logic [LANES-1:0]  rdPar,
  output logic [LANES-1:0]  laneStrobe,
  output logic              devSel,
  output logic [DATA_W-1:0] dataWe,
  output logic [LANES-1:0]  parWe,
  output logic [DATA_W-1:0] wrDataQ,
  output logic [LANES-1:0]  wrParQ,
  output logic [DATA_W-1:0] rdDataQ,
  output logic [LANES-1:0]  rdParQ,
  output logic              driveEn,
  output logic              clkRun
);
  logic        devHit;
  ctrlStrobe_t ctrl;

  sram_sel_decode u_dec (
    .chipEnN (chipEnN),
    .selHi   (selHi),
    .selLoN  (selLoN),
    .sleepReq(sleepReq),
    .devHit  (devHit),
    .clkRun  (clkRun)
  );

  sram_lane_ctrl_core u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkRun   (clkRun),
    .devHit   (devHit),
    .allWriteN(allWriteN),
    .laneGateN(laneGateN),
    .laneWrN  (laneWrN),
    .ctrl     (ctrl)
  );

  sram_lane_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .clkRun (clkRun),
    .ctrl   (ctrl),
    .outEnN (outEnN),
    .wrData (wrData),
    .wrPar  (wrPar),
    .rdData (rdData),
    .rdPar  (rdPar),
    .dataWe (dataWe),
    .parWe  (parWe),
    .wrDataQ(wrDataQ),
    .wrParQ (wrParQ),
    .rdDataQ(rdDataQ),
    .rdParQ (rdParQ),
    .driveEn(driveEn)
  );

  assign laneStrobe = ctrl.laneWr;
  assign devSel     = ctrl.devSel;
endmodule

// File: tb/sram_byte_ctrl_tb.sv
`timescale 1ns/1ps
module sram_byte_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0, chipEnN = 1'b1, selHi = 1'b0, selLoN = 1'b1;
  logic allWriteN = 1'b1, laneGateN = 1'b1, outEnN = 1'b1;
  logic [3:0]  laneWrN = 4'hF, wrPar = '0, rdPar = '0;
  logic [31:0] wrData = '0, rdData = '0;
  logic [3:0]  laneStrobe, parWe, wrParQ, rdParQ;
  logic [31:0] dataWe, wrDataQ, rdDataQ;
  logic        devSel, driveEn, clkRun;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_byte_ctrl u_dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .chipEnN(chipEnN), .selHi(selHi),
    .selLoN(selLoN), .allWriteN(allWriteN), .laneGateN(laneGateN), .laneWrN(laneWrN),
    .outEnN(outEnN), .wrData(wrData), .wrPar(wrPar), .rdData(rdData), .rdPar(rdPar),
    .laneStrobe(laneStrobe), .devSel(devSel), .dataWe(dataWe), .parWe(parWe),
    .wrDataQ(wrDataQ), .wrParQ(wrParQ), .rdDataQ(rdDataQ), .rdParQ(rdParQ),
    .driveEn(driveEn), .clkRun(clkRun)
  );

  // Behavioural reference state
  bit        mSel;
  bit [3:0]  mStrobe;
  bit [31:0] mWrD, mRdD;
  bit [3:0]  mWrP, mRdP;
  string     mTag = "R10";
  bit        mSlept = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSel = 0; mStrobe = 0; mWrD = 0; mRdD = 0; mWrP = 0; mRdP = 0;
      mTag = "R10"; mSlept = 0;
    end else if (sleepReq) begin
      mSlept = 1;
    end else begin
      bit hit;
      hit = (chipEnN == 0) && (selHi == 1) && (selLoN == 0);
      mSel = hit;
      for (int i = 0; i < 4; i++)
        mStrobe[i] = hit && ((allWriteN == 0) || ((laneGateN == 0) && (laneWrN[i] == 0)));
      if (!hit) mTag = "R6";
      else if (!allWriteN) mTag = "R1";
      else if (!laneGateN) mTag = "R2";
      else mTag = "R3";
      mWrD = wrData; mWrP = wrPar; mRdD = rdData; mRdP = rdPar;
      mSlept = 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [31:0] expMask;
    string sTag;
    for (int i = 0; i < 4; i++) expMask[i*8 +: 8] = {8{mStrobe[i]}};
    sTag = mSlept ? "R9" : mTag;
    chk(sTag, {60'd0, laneStrobe}, {60'd0, mStrobe});
    chk(mSlept ? "R9" : "R5", {63'd0, devSel}, {63'd0, mSel});
    chk("R4", {28'd0, parWe, dataWe}, {28'd0, mStrobe, expMask});
    chk(mSlept ? "R9" : "R8", {28'd0, wrParQ, wrDataQ}, {28'd0, mWrP, mWrD});
    chk(mSlept ? "R9" : "R8", {28'd0, rdParQ, rdDataQ}, {28'd0, mRdP, mRdD});
    chk("R7", {63'd0, driveEn}, {63'd0, (!outEnN) && mSel && (mStrobe == 0)});
    chk("R9", {63'd0, clkRun}, {63'd0, !sleepReq});
  endtask

  always @(negedge clk) if (rstN && !done) compareAll();

  task automatic setIn(input bit ce, input bit s0, input bit s1, input bit gw,
                       input bit bg, input bit [3:0] bw, input bit oe, input bit zz);
    @(negedge clk); #1;
    chipEnN = ce; selHi = s0; selLoN = s1; allWriteN = gw; laneGateN = bg;
    laneWrN = bw; outEnN = oe; sleepReq = zz;
    wrData = $urandom; rdData = $urandom; wrPar = 4'($urandom); rdPar = 4'($urandom);
  endtask

  initial begin
    // R10: reset state with active stimulus
    chipEnN = 0; selHi = 1; selLoN = 0; allWriteN = 0; wrData = 32'hA5A5_5A5A;
    repeat (3) @(negedge clk);
    chk("R10", {63'd0, devSel}, 64'd0);
    chk("R10", {60'd0, laneStrobe}, 64'd0);
    chk("R10", {32'd0, dataWe}, 64'd0);
    chk("R10", {32'd0, wrDataQ}, 64'd0);
    chk("R10", {32'd0, rdDataQ}, 64'd0);
    #1 rstN = 1;
    // R1: whole-word write with all lane enables inactive
    setIn(0, 1, 0, 0, 1, 4'hF, 0, 0);
    setIn(0, 1, 0, 0, 0, 4'hA, 0, 0);
    // R2: byte writes, alternating and single lanes
    setIn(0, 1, 0, 1, 0, 4'b1010, 0, 0);
    setIn(0, 1, 0, 1, 0, 4'b0101, 0, 0);
    for (int i = 0; i < 4; i++) setIn(0, 1, 0, 1, 0, ~(4'b1 << i), 0, 0);
    // R3: gate blocks lane enables
    setIn(0, 1, 0, 1, 1, 4'h0, 0, 0);
    // R6: each select dropped alone during a write
    setIn(1, 1, 0, 0, 0, 4'h0, 0, 0);
    setIn(0, 0, 0, 0, 0, 4'h0, 0, 0);
    setIn(0, 1, 1, 0, 0, 4'h0, 0, 0);
    // R7: read cycle, toggle output enable between edges
    setIn(0, 1, 0, 1, 1, 4'hF, 0, 0);
    @(posedge clk); #1;
    chk("R7", {63'd0, driveEn}, 64'd1);
    outEnN = 1; #0.5;
    chk("R7", {63'd0, driveEn}, 64'd0);
    outEnN = 0; #0.5;
    chk("R7", {63'd0, driveEn}, 64'd1);
    // R9: sleep with changing stimulus, then wake
    setIn(0, 1, 0, 0, 0, 4'h0, 0, 0);
    for (int i = 0; i < 5; i++) setIn(i[0], 1, 0, 0, 0, 4'($urandom), 0, 1);
    setIn(0, 1, 0, 1, 1, 4'hF, 0, 0);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      bit [3:0] r;
      r = 4'($urandom);
      setIn(r[0] & r[1], !(r[2] & r[3] & r[0]), r[1] & r[2] & r[3], 1'($urandom),
            1'($urandom), 4'($urandom), 1'($urandom), ($urandom % 8) == 0);
    end
    @(negedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20000 * 4);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule